// File: doc/BRIEF.md
# Loss of signal detector

This block watches a line receiver one bit interval at a time and decides whether the incoming signal has been lost. For each interval the receiver presents one sample: a valid strobe plus a "pulse present" flag. The receiver compares the amplitude against its threshold before the sample reaches this block. Loss is declared after a long enough run of intervals with no pulse. It is cleared only after a window of intervals, starting at a received pulse, shows an average pulse density of at least one in eight.

Two plain control inputs set the window length. A line-rate select picks a length of 175 intervals for the 1.544 Mb/s rate or 32 intervals for the 2.048 Mb/s rate. An extended-criteria select overrides both with 2048 intervals. The same length serves as the declare run and as the clear window. The block drives a loss status level, a sticky event flag that software clears by writing one, and a maskable interrupt.

Samples enter through a valid-only stream. The block accepts every sample in the cycle its valid is high and has no ready signal, so it never applies back-pressure. A cycle with valid low is not an interval and changes nothing in the detector.

Top module: `los_detector`

## Requirements
- R1: With `los` low, the interval that completes a run of W consecutive valid samples with `smp_pulse`=0 sets `los` high at the next clock edge. One fewer such sample leaves it low.
- R2: A valid sample with `smp_pulse`=1 while `los` is low restarts the zero run, so `los` is still low after that edge.
- R3: While `los` is high, a clear window opens only on a valid sample with `smp_pulse`=1. Valid samples with no pulse before that sample are not counted in any window.
- R4: A window closes on its W-th valid sample, counting the opening pulse as sample 1. If the pulse count P over those W samples satisfies 8*P >= W, `los` goes low at that edge.
- R5: A window that fails the density test is dropped and `los` stays high. The next window opens at the next pulse.
- R6: W is 2048 when `crit_alt`=1. When `crit_alt`=0, W is 32 with `e1_mode`=1 and 175 with `e1_mode`=0.
- R7: A cycle with `smp_valid`=0 changes neither `los` nor any count, whatever `smp_pulse` is.
- R8: `irq_status` is set at every rising and every falling edge of `los` and stays set until `irq_clr` is high for a cycle. A set event in the same cycle takes priority over the clear.
- R9: `irq` equals `irq_status` when `irq_mask`=0 and is 0 when `irq_mask`=1.
- R10: After reset, `los`, `irq_status` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | One bit-interval sample is present |
| smp_pulse | input | 1 | The sampled interval contained a pulse |
| crit_alt | input | 1 | Select the extended 2048-interval criteria |
| e1_mode | input | 1 | 1: 2.048 Mb/s window, 0: 1.544 Mb/s window |
| irq_mask | input | 1 | Suppress the interrupt output |
| irq_clr | input | 1 | Write-one-to-clear strobe for the event flag |
| los | output | 1 | Loss of signal declared |
| irq_status | output | 1 | Sticky loss/restore event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks the local rules on every cycle. A rise of `los` must follow a valid zero sample, and a fall must follow a valid sample. A valid pulse while clear must keep `los` low. A cycle with no sample must leave `los` unchanged. The event flag must be set whenever `los` changes and must hold until it is cleared. Window lengths, the exact interval on which loss is declared, the density threshold and the failed-window restart cover hundreds of intervals. Only the bench scenarios can show these, by running a behavioural model in step with the design at every line rate and criteria setting.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef struct packed {
    logic valid;
    logic pulse;
  } los_sample_t;

  typedef enum logic {
    ST_OK   = 1'b0,
    ST_LOST = 1'b1
  } los_state_e;
endpackage

// File: rtl/los_win_sel.sv
module los_win_sel #(
  parameter int T1_N  = 175,
  parameter int E1_N  = 32,
  parameter int ALT_N = 2048,
  parameter int CW    = 12
) (
  input  logic          crit_alt,
  input  logic          e1_mode,
  output logic [CW-1:0] win_len
);
  always_comb begin
    if (crit_alt)     win_len = CW'(ALT_N);
    else if (e1_mode) win_len = CW'(E1_N);
    else              win_len = CW'(T1_N);
  end
endmodule

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int CW = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  los_pkg::los_sample_t  smp,
  input  logic [CW-1:0]         win_len,
  output logic                  declare
);
  logic [CW-1:0] zcnt;
  logic [CW:0]   znext;

  assign znext   = {1'b0, zcnt} + (CW+1)'(1);
  assign declare = en && smp.valid && !smp.pulse && (znext >= {1'b0, win_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                zcnt <= '0;
    else if (!en || declare)   zcnt <= '0;
    else if (smp.valid)        zcnt <= smp.pulse ? '0 : znext[CW-1:0];
  end
endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter int CW = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  los_pkg::los_sample_t  smp,
  input  logic [CW-1:0]         win_len,
  output logic                  clear
);
  logic          active;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] pcnt;
  logic [CW:0]   wnext;
  logic [CW:0]   pnext;
  logic          last;
  logic          dense;

  assign wnext = {1'b0, wcnt} + (CW+1)'(1);
  assign pnext = {1'b0, pcnt} + (CW+1)'(smp.pulse);
  assign last  = en && smp.valid && active && (wnext >= {1'b0, win_len});
  assign dense = {pnext, 3'b000} >= (CW+4)'(win_len);
  assign clear = last && dense;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (!en) begin
      active <= 1'b0;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (smp.valid) begin
      if (!active) begin
        if (smp.pulse) begin
          active <= 1'b1;
          wcnt   <= CW'(1);
          pcnt   <= CW'(1);
        end
      end else if (last) begin
        active <= 1'b0;
        wcnt   <= '0;
        pcnt   <= '0;
      end else begin
        wcnt <= wnext[CW-1:0];
        pcnt <= pnext[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/los_irq_sticky.sv
module los_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_w1c,
  input  logic mask,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= 1'b0;
    else if (set_evt)  status <= 1'b1;
    else if (clr_w1c)  status <= 1'b0;
  end

  assign irq = status && !mask;
endmodule

// File: rtl/los_detector.sv
module los_detector #(
  parameter int T1_N  = 175,
  parameter int E1_N  = 32,
  parameter int ALT_N = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic smp_pulse,
  input  logic crit_alt,
  input  logic e1_mode,
  input  logic irq_mask,
  input  logic irq_clr,
  output logic los,
  output logic irq_status,
  output logic irq
);
  import los_pkg::*;

  localparam int MAXN = (ALT_N > T1_N) ? ((ALT_N > E1_N) ? ALT_N : E1_N)
                                       : ((T1_N > E1_N) ? T1_N : E1_N);
  localparam int CW   = $clog2(MAXN + 1);

  los_sample_t   smp;
  logic [CW-1:0] win_len;
  los_state_e    state;
  logic          declare;
  logic          clear;

  assign smp.valid = smp_valid;
  assign smp.pulse = smp_pulse;

  los_win_sel #(.T1_N(T1_N), .E1_N(E1_N), .ALT_N(ALT_N), .CW(CW)) u_sel (
    .crit_alt (crit_alt),
    .e1_mode  (e1_mode),
    .win_len  (win_len)
  );

  los_zero_run #(.CW(CW)) u_zero (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state == ST_OK),
    .smp     (smp),
    .win_len (win_len),
    .declare (declare)
  );

  los_density_win #(.CW(CW)) u_dens (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state == ST_LOST),
    .smp     (smp),
    .win_len (win_len),
    .clear   (clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= ST_OK;
    else if (declare) state <= ST_LOST;
    else if (clear)   state <= ST_OK;
  end

  assign los = (state == ST_LOST);

  los_irq_sticky u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (declare || clear),
    .clr_w1c (irq_clr),
    .mask    (irq_mask),
    .status  (irq_status),
    .irq     (irq)
  );
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic smp_pulse,
  input logic irq_clr,
  input logic los,
  input logic irq_status
);
  // R1: a declare edge always follows a valid zero sample
  a_r1_declare_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(smp_valid && !smp_pulse));

  // R2: a valid pulse while clear keeps los low
  a_r2_pulse_blocks_declare: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && smp_valid && smp_pulse) |=> !los);

  // R4: a clear edge always follows a valid sample
  a_r4_clear_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(smp_valid));

  // R7: no sample, no change
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(los));

  // R8: every change of los raises the event flag
  a_r8_flag_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los) || $fell(los)) |-> irq_status);

  // R8: the event flag holds until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !irq_clr) |=> irq_status);
endmodule

bind los_detector los_detector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_pulse  (smp_pulse),
  .irq_clr    (irq_clr),
  .los        (los),
  .irq_status (irq_status)
);

// File: tb/sim_los_detector.sv
`timescale 1ns/1ps
module sim_los_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_pulse = 1'b0;
  logic crit_alt = 1'b0, e1_mode = 1'b0;
  logic irq_mask = 1'b0, irq_clr = 1'b0;
  logic los, irq_status, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  los_detector u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_pulse(smp_pulse),
    .crit_alt(crit_alt), .e1_mode(e1_mode), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .los(los), .irq_status(irq_status), .irq(irq)
  );

  // behavioural reference model
  bit m_los, m_st, m_act;
  int m_z, m_wc, m_pc;

  function automatic int win();
    if (crit_alt) return 2048;
    if (e1_mode)  return 32;
    return 175;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_los = 0; m_st = 0; m_act = 0; m_z = 0; m_wc = 0; m_pc = 0;
    end else begin
      int n;
      bit ev;
      n = win();
      ev = 0;
      if (smp_valid) begin
        if (!m_los) begin
          if (smp_pulse) m_z = 0;
          else begin
            m_z++;
            if (m_z >= n) begin m_los = 1; m_z = 0; m_act = 0; ev = 1; end
          end
        end else if (!m_act) begin
          if (smp_pulse) begin m_act = 1; m_wc = 1; m_pc = 1; end
        end else begin
          m_wc++;
          if (smp_pulse) m_pc++;
          if (m_wc >= n) begin
            m_act = 0;
            if (m_pc * 8 >= n) begin m_los = 0; m_z = 0; ev = 1; end
          end
        end
      end
      if (ev) m_st = 1;
      else if (irq_clr) m_st = 0;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 R4 los vs model", los, m_los);
      chk("R8 irq_status vs model", irq_status, m_st);
      chk("R9 irq vs model", irq, m_st && !irq_mask);
    end
  end

  task automatic send(bit p);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_pulse = p;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0;
    smp_pulse = 1'b0;
  endtask

  task automatic zeros(int k);
    for (int i = 0; i < k; i++) send(1'b0);
  endtask

  task automatic do_reset(bit alt, bit e1);
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    crit_alt = alt;
    e1_mode = e1;
    irq_clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_clear();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  initial begin
    do_reset(1'b0, 1'b0);
    chk("R10 los after reset", los, 1'b0);
    chk("R10 irq_status after reset", irq_status, 1'b0);
    chk("R10 irq after reset", irq, 1'b0);

    // 1.544 Mb/s window, W = 175
    zeros(100);
    send(1'b1);
    zeros(174);
    idle();
    chk("R2 pulse restarted zero run", los, 1'b0);
    send(1'b0);
    idle();
    chk("R1 declared at 175th zero", los, 1'b1);
    chk("R8 flag set on declare", irq_status, 1'b1);
    chk("R9 irq unmasked", irq, 1'b1);
    @(negedge clk) irq_mask = 1'b1;
    @(negedge clk);
    chk("R9 irq masked", irq, 1'b0);
    irq_mask = 1'b0;
    write_clear();
    chk("R8 flag cleared by write", irq_status, 1'b0);

    // R7: idle cycles with pulse high do nothing
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_pulse = 1'b1;
    end
    @(negedge clk);
    smp_pulse = 1'b0;
    chk("R7 idle cycles ignored", los, 1'b1);

    // R3 zeros before a pulse open no window; R5 sparse window fails
    zeros(20);
    for (int i = 0; i < 175; i++) send(i % 9 == 0);
    idle();
    chk("R5 sparse window keeps los", los, 1'b1);
    zeros(5);
    for (int i = 0; i < 174; i++) send(i % 8 == 0);
    idle();
    chk("R3 window not yet complete", los, 1'b1);
    send(1'b0);
    idle();
    chk("R4 dense window clears", los, 1'b0);
    chk("R8 flag set on clear", irq_status, 1'b1);

    // R6: 2.048 Mb/s window, W = 32
    do_reset(1'b0, 1'b1);
    zeros(31);
    idle();
    chk("R6 E1 not declared at 31", los, 1'b0);
    send(1'b0);
    idle();
    chk("R6 E1 declared at 32", los, 1'b1);
    for (int i = 0; i < 32; i++) send(i % 8 == 0);
    idle();
    chk("R6 E1 cleared with 4 pulses", los, 1'b0);

    // R6: extended criteria, W = 2048
    do_reset(1'b1, 1'b0);
    zeros(2047);
    idle();
    chk("R6 extended not declared at 2047", los, 1'b0);
    send(1'b0);
    idle();
    chk("R6 extended declared at 2048", los, 1'b1);
    for (int i = 0; i < 2048; i++) send(1'b1);
    idle();
    chk("R6 extended cleared", los, 1'b0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule